// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Hold

This block receives asynchronous serial words on a single line input. The line is idle high. A falling edge arms a half-bit timer, and the line is checked again at the centre of the start bit. A low level at that point starts a frame. A high level is treated as a glitch, and the receiver goes back to waiting for an edge. Each data bit is then sampled once at its centre. Bits arrive least significant first. The word is 8 bits wide, or 7 bits in short mode.

Timing comes from a bit-rate tick that runs at sixteen times the baud rate. Every completed word goes to a one-word receive buffer and raises a buffer-full flag. The consumer clears that flag with a one-cycle read strobe. If a word completes while the buffer is still full, the new word is dropped and the buffered word is kept. An overrun flag is then raised and stays set until its own clear strobe. After the last data bit the receiver waits one bit period into the stop bit, then re-arms. Dropping the enable input returns the receiver to idle at once.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset the buffer-full flag is 0, the overrun flag is 0 and the buffer output is 0.
- R2: While `rx_en` is 0 no frame is received, and clearing `rx_en` in the middle of a frame abandons it. A complete frame sent after re-enabling is received correctly.
- R3: A low pulse on the line that is high again at the 8th tick after the falling edge is rejected as noise. No word is produced, and the receiver waits for a new falling edge.
- R4: In 8-bit mode (`short_mode` = 0), the first data bit on the line lands in buffer bit 0 and the eighth lands in bit 7.
- R5: In 7-bit mode (`short_mode` = 1), the seven received bits fill buffer bits 0 to 6, first bit in bit 0, and buffer bit 7 is 0.
- R6: The buffer-full flag goes to 1 when a word is transferred and goes to 0 on the clock after a one-cycle `rd_stb`.
- R7: A word that completes while the buffer-full flag is 1 sets the overrun flag. That word is discarded, and the buffer keeps its previous contents.
- R8: The overrun flag stays 1 through reads of the buffer and returns to 0 only after `ovr_clr`.
- R9: After one stop-bit period the receiver re-arms, so frames sent back to back with a single stop bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable; 0 forces idle |
| tick | input | 1 | One-cycle pulse at 16x baud rate |
| short_mode | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| rd_stb | input | 1 | One-cycle strobe that clears the buffer-full flag |
| ovr_clr | input | 1 | One-cycle strobe that clears the overrun flag |
| rx_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Buffer holds an unread word |
| rx_overrun | output | 1 | A word was lost because the buffer was full |

## Verification
A timing counter or bit counter that drifts shows up at the ports within the same frame. The buffered byte comes out shifted, or bit 7 is non-zero in short mode, or the full flag rises one bit period early or late. A state machine that fails to re-arm shows up on the next frame, which never sets the full flag, so the scoreboard finds a missing word. A wrong overrun decision shows at the first write into a full buffer: either the byte at `rx_data` changes, or `rx_overrun` stays low.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uart_rx_seq.sv
// Line synchroniser, start qualification and bit timing.
module uart_rx_seq
    import uart_rx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int MAX_BITS      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic rx_en,
    input  logic tick,
    input  logic short_mode,
    output logic shift_en,
    output logic bit_val,
    output logic word_done
);
    localparam int CW   = $clog2(TICKS_PER_BIT);
    localparam int BW   = $clog2(MAX_BITS + 1);
    localparam int HALF = TICKS_PER_BIT / 2;

    typedef struct packed {
        rx_state_e      state;
        logic [CW-1:0]  cnt;
        logic [BW-1:0]  nbit;
        logic [1:0]     sync;
        logic           prev;
        logic           done;
    } seq_t;

    seq_t q, d;
    logic          line_s;
    logic [BW-1:0] last_idx;

    assign line_s   = q.sync[1];
    assign last_idx = short_mode ? BW'(MAX_BITS - 2) : BW'(MAX_BITS - 1);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.sync   = {q.sync[0], rxd};
        d.prev   = line_s;
        shift_en = 1'b0;
        unique case (q.state)
            RX_IDLE: begin
                if (q.prev && !line_s) begin
                    d.state = RX_START;
                    d.cnt   = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == CW'(HALF - 1)) begin
                        d.cnt  = '0;
                        d.nbit = '0;
                        d.state = line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.cnt == CW'(TICKS_PER_BIT - 1)) begin
                        shift_en = 1'b1;
                        d.cnt    = '0;
                        d.nbit   = q.nbit + 1'b1;
                        if (q.nbit == last_idx) begin
                            d.done  = 1'b1;
                            d.state = RX_STOP;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (q.cnt == CW'(TICKS_PER_BIT - 1)) begin
                        d.cnt   = '0;
                        d.state = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = RX_IDLE;
        endcase
        if (!rx_en) begin
            d.state  = RX_IDLE;
            d.cnt    = '0;
            d.done   = 1'b0;
            shift_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= RX_IDLE;
            q.cnt   <= '0;
            q.nbit  <= '0;
            q.sync  <= 2'b11;
            q.prev  <= 1'b1;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bit_val   = line_s;
    assign word_done = q.done;

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (q.state == RX_IDLE) && !word_done);

    // R3
    noise_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && q.state == RX_START && tick && q.cnt == CW'(HALF - 1) && line_s)
        |=> (q.state == RX_IDLE));

    // R9
    stop_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (q.state == RX_STOP) && (q.cnt == '0));
endmodule

// File: rtl/uart_rx_shift.sv
// Receive shift register: new bits enter at the top and move toward bit 0.
module uart_rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             short_mode,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (shift_en) d.sh = {bit_in, q.sh[WIDTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.sh <= '0;
        else        q    <= d;
    end

    // A short word is right-justified: its first bit sits one place up.
    assign word = short_mode ? {1'b0, q.sh[WIDTH-1:1]} : q.sh;

    // R4
    shift_in_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q.sh[WIDTH-1] == $past(bit_in)));
endmodule

// File: rtl/uart_rx_buf.sv
// One-word receive buffer with full and overrun flags.
module uart_rx_buf #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    input  logic             rd_stb,
    input  logic             ovr_clr,
    output logic [WIDTH-1:0] data,
    output logic             full,
    output logic             overrun
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             full;
        logic             ovr;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (rd_stb)  d.full = 1'b0;
        if (ovr_clr) d.ovr  = 1'b0;
        if (load) begin
            if (q.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = word;
                d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.data <= '0;
            q.full <= 1'b0;
            q.ovr  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data    = q.data;
    assign full    = q.full;
    assign overrun = q.ovr;

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full) |=> overrun);

    // R7
    old_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full) |=> $stable(data));

    // R6
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !load) |=> !full);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 tick,
    input  logic                 short_mode,
    input  logic                 rd_stb,
    input  logic                 ovr_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 rx_overrun
);
    logic                 shift_en;
    logic                 bit_val;
    logic                 word_done;
    logic [DATA_BITS-1:0] word;

    uart_rx_seq #(.TICKS_PER_BIT(TICKS_PER_BIT), .MAX_BITS(DATA_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .tick(tick),
        .short_mode(short_mode), .shift_en(shift_en), .bit_val(bit_val),
        .word_done(word_done)
    );

    uart_rx_shift #(.WIDTH(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(bit_val),
        .short_mode(short_mode), .word(word)
    );

    uart_rx_buf #(.WIDTH(DATA_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(word_done), .word(word),
        .rd_stb(rd_stb), .ovr_clr(ovr_clr), .data(rx_data),
        .full(rx_full), .overrun(rx_overrun)
    );

    // R5
    short_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && short_mode && !rx_full) |=> (rx_data[DATA_BITS-1] == 1'b0));
endmodule

// File: tb/tb_uart_rx_hold.sv
`timescale 1ns/1ps
module tb_uart_rx_hold;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       short_mode = 1'b0;
    logic       man_rd = 1'b0;
    logic       mon_rd = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       rd_stb;
    logic       tick;
    logic [1:0] div = 2'd0;
    logic [7:0] rx_data;
    logic       rx_full, rx_overrun;
    logic       auto_read = 1'b0;

    int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) div <= rst_n ? div + 2'd1 : 2'd0;
    assign tick   = (div == 2'd3);
    assign rd_stb = man_rd | mon_rd;

    uart_rx_hold dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .tick(tick),
        .short_mode(short_mode), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
        .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    // Monitor: pops the scoreboard and reads the buffer whenever it fills.
    always @(negedge clk) begin
        if (auto_read && rx_full && !mon_rd) begin
            m_chk++;
            if (exp_q.size() == 0) begin
                m_err++;
                $display("FAIL R4 unexpected word: actual %h expected none", rx_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rx_data !== e) begin
                    m_err++;
                    $display("FAIL R4/R5 word: actual %h expected %h", rx_data, e);
                end
            end
            mon_rd = 1'b1;
        end else begin
            mon_rd = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (!tick);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] v, input bit seven, input bit push);
        int nb;
        nb = seven ? 7 : 8;
        if (push) exp_q.push_back(seven ? {1'b0, v[6:0]} : v);
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < nb; i++) begin
            rxd = v[i];
            wait_ticks(16);
        end
        rxd = 1'b1;
        wait_ticks(16);
    endtask

    task automatic pulse_rd();
        @(negedge clk); man_rd = 1'b1;
        @(negedge clk); man_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_err + m_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_full == 1'b0, "R1 full", rx_full, 0);
        check(rx_overrun == 1'b0, "R1 overrun", rx_overrun, 0);
        check(rx_data == 8'h00, "R1 data", rx_data, 0);

        // R2 disabled: frame ignored
        send_frame(8'hA5, 1'b0, 1'b0);
        wait_ticks(4);
        check(rx_full == 1'b0, "R2 disabled full", rx_full, 0);
        check(rx_data == 8'h00, "R2 disabled data", rx_data, 0);

        rx_en = 1'b1;
        auto_read = 1'b1;
        wait_ticks(20);

        // R4 8-bit patterns
        send_frame(8'hA5, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b1);
        send_frame(8'hFF, 1'b0, 1'b1);
        send_frame(8'h00, 1'b0, 1'b1);
        send_frame(8'h01, 1'b0, 1'b1);
        send_frame(8'h80, 1'b0, 1'b1);

        // R9 back to back, single stop bit each
        send_frame(8'h5A, 1'b0, 1'b1);
        send_frame(8'hC3, 1'b0, 1'b1);
        send_frame(8'h96, 1'b0, 1'b1);

        // R5 7-bit mode
        short_mode = 1'b1;
        wait_ticks(4);
        send_frame(8'hD5, 1'b1, 1'b1);
        send_frame(8'h7F, 1'b1, 1'b1);
        send_frame(8'h01, 1'b1, 1'b1);
        send_frame(8'hC0, 1'b1, 1'b1);
        short_mode = 1'b0;
        wait_ticks(20);

        // R3 noise glitch of 3 ticks
        rxd = 1'b0; wait_ticks(3);
        rxd = 1'b1; wait_ticks(30);
        check(rx_full == 1'b0, "R3 glitch rejected", rx_full, 0);
        send_frame(8'h69, 1'b0, 1'b1);

        // R2 abandon mid-frame
        rxd = 1'b0; wait_ticks(40);
        rx_en = 1'b0; rxd = 1'b1; wait_ticks(200);
        check(rx_full == 1'b0, "R2 abandoned frame", rx_full, 0);
        rx_en = 1'b1; wait_ticks(4);
        send_frame(8'hE7, 1'b0, 1'b1);
        wait_ticks(4);
        check(exp_q.size() == 0, "R4/R9 all words delivered", exp_q.size(), 0);

        // R6/R7/R8 manual buffer handling
        auto_read = 1'b0;
        wait_ticks(2);
        send_frame(8'h4B, 1'b0, 1'b0);
        check(rx_full == 1'b1, "R6 full set", rx_full, 1);
        check(rx_data == 8'h4B, "R6 data", rx_data, 8'h4B);
        send_frame(8'hB4, 1'b0, 1'b0);
        check(rx_overrun == 1'b1, "R7 overrun set", rx_overrun, 1);
        check(rx_data == 8'h4B, "R7 old word kept", rx_data, 8'h4B);
        check(rx_full == 1'b1, "R7 still full", rx_full, 1);
        pulse_rd();
        check(rx_full == 1'b0, "R6 read clears full", rx_full, 0);
        check(rx_overrun == 1'b1, "R8 overrun sticky after read", rx_overrun, 1);
        check(rx_data == 8'h4B, "R6 data after read", rx_data, 8'h4B);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        check(rx_overrun == 1'b0, "R8 overrun cleared", rx_overrun, 0);
        send_frame(8'h2D, 1'b0, 1'b0);
        check(rx_full == 1'b1 && rx_data == 8'h2D, "R6 new word after read", rx_data, 8'h2D);
        check(rx_overrun == 1'b0, "R8 no spurious overrun", rx_overrun, 0);

        wait_ticks(4);
        finish_run();
    end
endmodule